// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame whose destination is a group (multicast) address should be kept. It folds the last two octets of the 48-bit destination address into a hash. That hash selects one bit of a table held in 32-bit words. The frame is accepted when the selected bit is set.

A two-bit filter type chooses which address bits form the hash. The window slides across octets 4 and 5 while the total shift across both octets stays at 8 bits. Software loads the table one word at a time through a simple write port.

For each frame, the receive path presents the destination address with a strobe. One clock later the block returns a registered verdict. The verdict says whether the address was a group address and, if so, whether it passed the table. Addresses without the group bit get a not-applicable result and are never accepted. After reset the table is empty, so every multicast address is rejected until words are written.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, all table words are zero and `res_valid`, `res_group` and `res_accept` are low. Every lookup made before any table write returns `res_accept` = 0.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `look_valid` was high, and low otherwise. Back-to-back lookups each produce their own result.
- R3: The hash width is H = log2(NUM_WORDS*32) and the base shift is B = H-8. Filter types 0, 1, 2 and 3 (the `filt_type` encoding) use shift S = B+0, B+1, B+2 and B+4. The hash is the low H bits of ((octet4 >> (8-S)) | (octet5 << S)).
- R4: `look_addr` carries octet 0 (first transmitted) in bits 47:40 and octet 5 in bits 7:0, so octet4 = bits 15:8. With the default 128 words and address 01-AA-00-12-34-56, types 0 to 3 give hashes 0x563, 0xAC6, 0x58D and 0x634.
- R5: The table word index is hash[H-1:5] and the bit within that word is hash[4:0]. A group address is accepted exactly when that bit is 1.
- R6: An address whose group bit (bit 40 of `look_addr`, bit 0 of octet 0) is clear returns `res_group` = 0 and `res_accept` = 0, whatever the table holds.
- R7: A table write presented in the same cycle as a lookup does not affect that lookup's verdict. It does affect every later lookup.
- R8: A write with `tbl_wr_en` high replaces only the word selected by `tbl_wr_idx`. All other words keep their contents.
- R9: The filter type is sampled together with the address, so consecutive lookups of the same address under different types use their own hashes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_idx | input | IDX_W (7) | Index of the table word to write |
| tbl_wr_data | input | 32 | New table word contents |
| filt_type | input | 2 | Hash window selection (0 to 3) |
| look_valid | input | 1 | Destination address present this cycle |
| look_addr | input | 48 | Destination address, octet 0 in bits 47:40 |
| res_valid | output | 1 | Verdict valid, one cycle after `look_valid` |
| res_group | output | 1 | Looked-up address had its group bit set |
| res_accept | output | 1 | Group address hit a set table bit |

## Verification
The bench aims at the hash arithmetic for each filter type, using the worked address. A design with a wrong shift for one type, or octets taken in the wrong order, would hit a different word and reject an address that should pass. Single-bit tables probe the word/bit split of the hash. Neighbouring-word writes expose an index decoder that writes more than one word, or a bit select that is off by one. A write issued in the same cycle as a lookup catches a table that forwards new data too early. Non-group addresses against an all-ones table catch a design that filters unicast frames.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   localparam int OCTET_W   = 8;
   localparam int WORD_W    = 32;
   localparam int MAC_W     = 48;
   localparam int BIT_SEL_W = 5;
   localparam int TYPE_W    = 2;
   localparam int NUM_TYPES = 4;

   // filter type encodings
   typedef enum logic [TYPE_W-1:0] {
      FT_BASE  = 2'd0,
      FT_PLUS1 = 2'd1,
      FT_PLUS2 = 2'd2,
      FT_PLUS4 = 2'd3
   } ftype_e;

   // extra left shift of the high octet on top of the base shift
   function automatic int extra_shift(input int ft);
      case (ft)
         1:       return 1;
         2:       return 2;
         3:       return 4;
         default: return 0;
      endcase
   endfunction

   typedef struct packed {
      logic valid;
      logic group;
      logic accept;
   } verdict_t;

endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
   import mhf_pkg::*;
#(
   parameter int HASH_W = 12
) (
   input  logic [OCTET_W-1:0] oct_lo,
   input  logic [OCTET_W-1:0] oct_hi,
   input  logic [TYPE_W-1:0]  ftype,
   output logic [HASH_W-1:0]  hash
);

   localparam int BASE   = HASH_W - OCTET_W;
   localparam int WIDE_W = 2 * OCTET_W;

   logic [HASH_W-1:0] cand [NUM_TYPES];

   // one fixed-shift hash per filter type, selected afterwards
   for (genvar g = 0; g < NUM_TYPES; g++) begin : g_cand
      localparam int SH = BASE + extra_shift(g);
      logic [WIDE_W-1:0] lo_part;
      logic [WIDE_W-1:0] hi_part;
      logic [WIDE_W-1:0] merged;
      assign lo_part = {{OCTET_W{1'b0}}, oct_lo} >> (OCTET_W - SH);
      assign hi_part = {{OCTET_W{1'b0}}, oct_hi} << SH;
      assign merged  = lo_part | hi_part;
      assign cand[g] = merged[HASH_W-1:0];
   end

   assign hash = cand[ftype];

endmodule

// File: rtl/mhf_table.sv
module mhf_table
   import mhf_pkg::*;
#(
   parameter  int NUM_WORDS = 128,
   localparam int IDX_W     = $clog2(NUM_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic [IDX_W-1:0]     rd_idx,
   input  logic [BIT_SEL_W-1:0] rd_bit,
   output logic                 rd_hit
);

   localparam int FLAT_W = NUM_WORDS * WORD_W;

   logic [FLAT_W-1:0] flat;
   logic [WORD_W-1:0] rd_word;

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            q <= wr_data;
      end
      assign flat[g*WORD_W +: WORD_W] = q;
   end

   // read sees contents before any same-cycle write
   assign rd_word = flat[rd_idx*WORD_W +: WORD_W];
   assign rd_hit  = rd_word[rd_bit];

endmodule

// File: rtl/mhf_verdict.sv
module mhf_verdict
   import mhf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     look_valid,
   input  logic     look_group,
   input  logic     tbl_hit,
   output verdict_t verdict
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict <= '0;
      end else begin
         verdict.valid  <= look_valid;
         verdict.group  <= look_valid & look_group;
         verdict.accept <= look_valid & look_group & tbl_hit;
      end
   end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter  int NUM_WORDS = 128,
   localparam int IDX_W     = $clog2(NUM_WORDS),
   localparam int HASH_W    = $clog2(NUM_WORDS * WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_wr_en,
   input  logic [IDX_W-1:0]  tbl_wr_idx,
   input  logic [31:0]       tbl_wr_data,
   input  logic [1:0]        filt_type,
   input  logic              look_valid,
   input  logic [47:0]       look_addr,
   output logic              res_valid,
   output logic              res_group,
   output logic              res_accept
);

   localparam int GROUP_BIT = MAC_W - OCTET_W;

   // depth must be a power of two; widest shift must not exceed one octet
   if ((NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_pow2
      $error("NUM_WORDS must be a power of two");
   end
   if (NUM_WORDS < 8 || NUM_WORDS > 128) begin : g_bad_range
      $error("NUM_WORDS must lie between 8 and 128");
   end

   logic [OCTET_W-1:0] oct4;
   logic [OCTET_W-1:0] oct5;
   logic [HASH_W-1:0]  hash;
   logic               hit;
   verdict_t           vd;

   assign oct4 = look_addr[2*OCTET_W-1:OCTET_W];
   assign oct5 = look_addr[OCTET_W-1:0];

   mhf_hash #(.HASH_W(HASH_W)) u_hash (
      .oct_lo (oct4),
      .oct_hi (oct5),
      .ftype  (filt_type),
      .hash   (hash)
   );

   mhf_table #(.NUM_WORDS(NUM_WORDS)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_idx  (tbl_wr_idx),
      .wr_data (tbl_wr_data),
      .rd_idx  (hash[HASH_W-1:BIT_SEL_W]),
      .rd_bit  (hash[BIT_SEL_W-1:0]),
      .rd_hit  (hit)
   );

   mhf_verdict u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_valid (look_valid),
      .look_group (look_addr[GROUP_BIT]),
      .tbl_hit    (hit),
      .verdict    (vd)
   );

   assign res_valid  = vd.valid;
   assign res_group  = vd.group;
   assign res_accept = vd.accept;

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        tbl_wr_en,
   input logic        look_valid,
   input logic [47:0] look_addr,
   input logic        res_valid,
   input logic        res_group,
   input logic        res_accept
);

   logic any_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         any_wr <= 1'b0;
      else if (tbl_wr_en)
         any_wr <= 1'b1;
   end

   // R2: a lookup always yields a verdict next cycle
   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      look_valid |=> res_valid);

   // R2: no verdict without a lookup
   a_r2_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
      !look_valid |=> !res_valid);

   // R6: individual addresses are never accepted
   a_r6_not_group: assert property (@(posedge clk) disable iff (!rst_n)
      (look_valid && !look_addr[40]) |=> (!res_group && !res_accept));

   // R6: group flag reported for group addresses
   a_r6_group_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (look_valid && look_addr[40]) |=> res_group);

   // R1: empty table rejects; R7: same-cycle write not seen
   a_r1_empty_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(any_wr)) |-> !res_accept);

   // R5: acceptance only on a valid group verdict
   a_r5_accept_scope: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept |-> (res_valid && res_group));

endmodule

bind mcast_hash_filter mhf_checker u_mhf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .tbl_wr_en  (tbl_wr_en),
   .look_valid (look_valid),
   .look_addr  (look_addr),
   .res_valid  (res_valid),
   .res_group  (res_group),
   .res_accept (res_accept)
);

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;

   localparam int NW = 128;
   localparam int IW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_wr_en = 1'b0;
   logic [IW-1:0] tbl_wr_idx = '0;
   logic [31:0]   tbl_wr_data = '0;
   logic [1:0]    filt_type = '0;
   logic          look_valid = 1'b0;
   logic [47:0]   look_addr = '0;
   logic          res_valid, res_group, res_accept;

   always #2 clk = ~clk;

   mcast_hash_filter uut (
      .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
      .tbl_wr_data(tbl_wr_data), .filt_type(filt_type), .look_valid(look_valid),
      .look_addr(look_addr), .res_valid(res_valid), .res_group(res_group),
      .res_accept(res_accept)
   );

   typedef struct {
      bit    group;
      bit    accept;
      string tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;
   logic [31:0] shadow [NW];

   localparam logic [47:0] EXAMPLE = 48'h01AA_0012_3456;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] model_hash(input logic [47:0] a, input logic [1:0] t);
      int          sh;
      logic [15:0] w;
      sh = 4 + ((t == 2'd3) ? 4 : int'(t));
      w  = ({8'h00, a[15:8]} >> (8 - sh)) | ({8'h00, a[7:0]} << sh);
      return w[11:0];
   endfunction

   function automatic bit model_accept(input logic [47:0] a, input logic [1:0] t);
      logic [11:0] h;
      h = model_hash(a, t);
      return a[40] & shadow[h[11:5]][h[4:0]];
   endfunction

   // type-3 hash is {octet5[3:0], octet4}: build an address hitting hash h
   function automatic logic [47:0] addr_for(input logic [11:0] h);
      return {8'h01, 8'h00, 8'h5E, 8'h00, h[7:0], 4'h0, h[11:8]};
   endfunction

   task automatic push_look(input logic [47:0] a, input logic [1:0] t,
                            input bit g, input bit acc, input string tag);
      exp_t e;
      tbl_wr_en  = 1'b0;
      look_valid = 1'b1;
      look_addr  = a;
      filt_type  = t;
      e.group = g; e.accept = acc; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic look(input logic [47:0] a, input logic [1:0] t, input string tag);
      @(negedge clk);
      push_look(a, t, a[40], model_accept(a, t), tag);
   endtask

   task automatic look_exp(input logic [47:0] a, input logic [1:0] t,
                           input bit acc, input string tag);
      @(negedge clk);
      push_look(a, t, a[40], acc, tag);
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      look_valid  = 1'b0;
      tbl_wr_en   = 1'b1;
      tbl_wr_idx  = IW'(idx);
      tbl_wr_data = d;
      shadow[idx] = d;
   endtask

   task automatic wr_look(input int idx, input logic [31:0] d,
                          input logic [47:0] a, input logic [1:0] t, input string tag);
      @(negedge clk);
      push_look(a, t, a[40], model_accept(a, t), tag);
      tbl_wr_en   = 1'b1;
      tbl_wr_idx  = IW'(idx);
      tbl_wr_data = d;
      shadow[idx] = d;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         look_valid = 1'b0;
         tbl_wr_en  = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2", "verdict without lookup", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(res_group == e.group, e.tag, "res_group", res_group, e.group);
            check(res_accept == e.accept, e.tag, "res_accept", res_accept, e.accept);
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   localparam logic [11:0] EX_H [4] = '{12'h563, 12'hAC6, 12'h58D, 12'h634};

   initial begin
      logic [47:0] a;
      for (int i = 0; i < NW; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
      check(res_accept == 1'b0, "R1", "res_accept after reset", res_accept, 0);
      // R1: empty table rejects multicast
      look_exp(EXAMPLE, 2'd0, 1'b0, "R1");
      look_exp(48'hFFFF_FFFF_FFFF, 2'd3, 1'b0, "R1");
      look_exp(addr_for(12'hFFF), 2'd3, 1'b0, "R1");
      idle(2);
      // R2: no verdict while idle
      check(res_valid == 1'b0, "R2", "res_valid idle", res_valid, 0);

      // R4: worked example, one bit per type, literal expectations
      for (int t = 0; t < 4; t++) begin
         wr(EX_H[t] >> 5, 32'h1 << EX_H[t][4:0]);
         for (int u = 0; u < 4; u++)
            look_exp(EXAMPLE, 2'(u), (u == t), "R4");
         wr(EX_H[t] >> 5, 32'h0);
      end

      // R5: single bit, probe neighbours
      wr(37, 32'h0000_0400);
      look_exp(addr_for({7'd37, 5'd10}), 2'd3, 1'b1, "R5");
      look_exp(addr_for({7'd37, 5'd11}), 2'd3, 1'b0, "R5");
      look_exp(addr_for({7'd36, 5'd10}), 2'd3, 1'b0, "R5");
      look_exp(addr_for({7'd38, 5'd10}), 2'd3, 1'b0, "R5");

      // R8: writing one word leaves its neighbours alone
      wr(60, 32'hFFFF_FFFF);
      wr(61, 32'h0000_0000);
      wr(59, 32'h0000_0000);
      look_exp(addr_for({7'd60, 5'd0}), 2'd3, 1'b1, "R8");
      look_exp(addr_for({7'd60, 5'd31}), 2'd3, 1'b1, "R8");
      look_exp(addr_for({7'd61, 5'd0}), 2'd3, 1'b0, "R8");
      look_exp(addr_for({7'd59, 5'd31}), 2'd3, 1'b0, "R8");
      look_exp(addr_for({7'd37, 5'd10}), 2'd3, 1'b1, "R8");

      // R7: same-cycle write not seen, next lookup sees it
      wr(90, 32'h0);
      wr_look(90, 32'h0000_0001, addr_for({7'd90, 5'd0}), 2'd3, "R7");
      look_exp(addr_for({7'd90, 5'd0}), 2'd3, 1'b1, "R7");
      wr_look(90, 32'h0, addr_for({7'd90, 5'd0}), 2'd3, "R7");
      look_exp(addr_for({7'd90, 5'd0}), 2'd3, 1'b0, "R7");

      // R3: random table, random addresses and types, back to back
      for (int i = 0; i < NW; i++) wr(i, $urandom());
      for (int i = 0; i < 200; i++) begin
         a = {16'($urandom()), 32'($urandom())};
         a[40] = 1'b1;
         look(a, 2'($urandom()), "R3");
      end

      // R9: same address, type switched every cycle
      for (int i = 0; i < 16; i++) begin
         a = {16'($urandom()), 32'($urandom())};
         a[40] = 1'b1;
         for (int t = 0; t < 4; t++) look(a, 2'(t), "R9");
      end

      // R6: individual addresses ignored by a full table
      for (int i = 0; i < NW; i++) wr(i, 32'hFFFF_FFFF);
      look_exp(48'h0000_0000_0000, 2'd0, 1'b0, "R6");
      look_exp(48'hFEFF_FFFF_FFFF, 2'd1, 1'b0, "R6");
      look_exp(48'h02AA_0012_3456, 2'd3, 1'b0, "R6");
      look_exp(EXAMPLE, 2'd2, 1'b1, "R6");

      idle(4);
      check(sb.size() == 0, "R2", "pending verdicts", sb.size(), 0);
      check(res_valid == 1'b0, "R2", "res_valid final idle", res_valid, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule